// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block is the first stage of a Reed-Solomon decoder for a shortened code over GF(2^8). The code has 16 parity bytes and can repair up to 8 bad bytes. A codeword is 204 bytes long: 188 data bytes followed by 16 check bytes. The field is generated by x^8+x^4+x^3+x^2+1 (0x11D), and the generator polynomial has the roots α^1 up to α^16.

The received bytes arrive one per accepted cycle, with the highest-order coefficient first. Strobes mark the first and the last byte of each codeword. For each root α^j, the block keeps an accumulator and applies Horner's rule to it. Each accumulator multiplies by its own fixed constant, built as an XOR network. When the last byte is accepted, the block registers all sixteen syndromes at once, pulses a done strobe and reports whether any syndrome is non-zero. An all-zero bank means the word is a codeword of the code. A non-zero bank goes to the key-equation solver further down the decoder.

Top module: `rs_syndrome_calc`

## Requirements
- R1: While reset is high and in the cycle after it, `syn_valid`, `err_flag` and every bit of `syn_bank` are 0.
- R2: For j = 1..16, the syndrome S_j equals the sum over i = 0..203 of r_i·α^(j·(203−i)), computed in GF(2^8) with polynomial 0x11D and α = 0x02. Here r_0 is the first byte received.
- R3: `syn_valid` is high for exactly one cycle. That cycle follows the clock edge that accepts a byte with `in_valid` and `in_eof` both high.
- R4: While `syn_valid` is high, `err_flag` is 1 exactly when at least one syndrome in the bank is non-zero.
- R5: A word produced by systematic encoding with g(x) = (x+α)(x+α^2)…(x+α^16) gives an all-zero bank and `err_flag` = 0.
- R6: Cycles with `in_valid` low leave the accumulators unchanged, whatever `in_sym`, `in_sof` and `in_eof` carry. A codeword sent with idle gaps yields the same bank as the same codeword sent without them.
- R7: An accepted byte with `in_sof` high discards any partial sums and starts the sums again from that byte.
- R8: A new codeword may start in the cycle right after the last byte of the previous one. Both codewords yield correct banks.
- R9: `syn_bank` and `err_flag` hold their values from one done pulse until the next.
- R10: The bank is packed with S_1 in bits [7:0] and S_j in bits [8j−1:8j−8].
- R11: `in_eof` is expected only on the 204th accepted byte counted from `in_sof`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte on `in_sym` is accepted this cycle |
| in_sof | input | 1 | Accepted byte is the first of a codeword |
| in_eof | input | 1 | Accepted byte is the last of a codeword |
| in_sym | input | 8 | Received byte, highest-order coefficient first |
| syn_valid | output | 1 | One-cycle pulse: a new syndrome bank is present |
| syn_bank | output | 128 | Sixteen syndromes, S_1 in the low byte |
| err_flag | output | 1 | Some syndrome in the bank is non-zero |

## Verification
The hardest case to reach from the ports is a non-zero bank whose exact values can be predicted without simply re-running Horner's rule. The bench produces it by systematically encoding a pseudo-random message. It then adds a single error value e at position p, at the first and last positions and in the middle, and compares each S_j with e·α^(j·(203−p)). Three further situations come about only through timing: a restart in the middle of a word, an eof followed at once by a new sof, and idle gaps inside a word. The bench drives each of them on purpose and checks the bank that follows.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

  localparam int unsigned GF_W = 8;

  // Multiply two field elements; poly holds the low GF_W bits of the field polynomial.
  function automatic logic [GF_W-1:0] gf_mul(input logic [GF_W-1:0] a,
                                             input logic [GF_W-1:0] b,
                                             input logic [GF_W:0]   poly);
    logic [GF_W-1:0] prod;
    logic [GF_W-1:0] sh;
    prod = '0;
    sh   = a;
    for (int i = 0; i < GF_W; i++) begin
      if (b[i]) prod = prod ^ sh;
      sh = {sh[GF_W-2:0], 1'b0} ^ (sh[GF_W-1] ? poly[GF_W-1:0] : '0);
    end
    return prod;
  endfunction

  // alpha (= x) raised to a small exponent
  function automatic logic [GF_W-1:0] gf_alpha_pow(input int unsigned e,
                                                   input logic [GF_W:0] poly);
    logic [GF_W-1:0] r;
    r = GF_W'(1);
    for (int unsigned k = 0; k < e; k++) r = gf_mul(r, GF_W'(2), poly);
    return r;
  endfunction

endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul
  import rs_syn_pkg::*;
#(
  parameter int unsigned  K_EXP      = 1,
  parameter logic [GF_W:0] FIELD_POLY = 9'h11D
) (
  input  logic [GF_W-1:0] din,
  output logic [GF_W-1:0] dout
);

  localparam logic [GF_W-1:0] KVAL = gf_alpha_pow(K_EXP, FIELD_POLY);

  logic [GF_W-1:0] terms [GF_W];

  generate
    for (genvar i = 0; i < GF_W; i++) begin : g_col
      localparam logic [GF_W-1:0] COL = gf_mul(GF_W'(1) << i, KVAL, FIELD_POLY);
      assign terms[i] = din[i] ? COL : '0;
    end
  endgenerate

  always_comb begin
    dout = '0;
    for (int i = 0; i < GF_W; i++) dout = dout ^ terms[i];
  end

endmodule

// File: rtl/rs_syn_cell.sv
module rs_syn_cell
  import rs_syn_pkg::*;
#(
  parameter int unsigned   ROOT_EXP   = 1,
  parameter logic [GF_W:0] FIELD_POLY = 9'h11D
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_sof,
  input  logic [GF_W-1:0] in_sym,
  output logic [GF_W-1:0] acc_next
);

  logic [GF_W-1:0] acc;
  logic [GF_W-1:0] acc_scaled;

  rs_gf_cmul #(.K_EXP(ROOT_EXP), .FIELD_POLY(FIELD_POLY)) u_cmul (
    .din  (acc),
    .dout (acc_scaled)
  );

  always_comb acc_next = in_sof ? in_sym : (acc_scaled ^ in_sym);

  always_ff @(posedge clk) begin
    if (rst)           acc <= '0;
    else if (in_valid) acc <= acc_next;
  end

  assert_sof_load_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> (acc == $past(in_sym)));

  assert_gap_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (acc == $past(acc)));

endmodule

// File: rtl/rs_syn_ctrl.sv
module rs_syn_ctrl #(
  parameter int unsigned N_SYM = 204
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_sof,
  input  logic in_eof,
  output logic accept_eof
);

  localparam int unsigned CNT_W = $clog2(N_SYM + 1);

  logic [CNT_W-1:0] sym_cnt;

  assign accept_eof = in_valid && in_eof;

  always_ff @(posedge clk) begin
    if (rst)                     sym_cnt <= '0;
    else if (in_valid && in_sof) sym_cnt <= CNT_W'(1);
    else if (in_valid)           sym_cnt <= sym_cnt + CNT_W'(1);
  end

  assert_len_eof_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eof && !in_sof) |-> (sym_cnt == CNT_W'(N_SYM - 1)));

endmodule

// File: rtl/rs_syndrome_calc.sv
module rs_syndrome_calc
  import rs_syn_pkg::*;
#(
  parameter int unsigned   N_SYM      = 204,
  parameter int unsigned   N_ROOTS    = 16,
  parameter int unsigned   FIRST_ROOT = 1,
  parameter logic [GF_W:0] FIELD_POLY = 9'h11D
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic                    in_eof,
  input  logic [GF_W-1:0]         in_sym,
  output logic                    syn_valid,
  output logic [N_ROOTS*GF_W-1:0] syn_bank,
  output logic                    err_flag
);

  logic [GF_W-1:0] acc_next [N_ROOTS];
  logic            accept_eof;
  logic            any_nz;

  rs_syn_ctrl #(.N_SYM(N_SYM)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .accept_eof (accept_eof)
  );

  generate
    for (genvar g = 0; g < N_ROOTS; g++) begin : g_cell
      rs_syn_cell #(.ROOT_EXP(FIRST_ROOT + g), .FIELD_POLY(FIELD_POLY)) u_cell (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_sym   (in_sym),
        .acc_next (acc_next[g])
      );
    end
  endgenerate

  always_comb begin
    any_nz = 1'b0;
    for (int g = 0; g < N_ROOTS; g++) any_nz = any_nz | (|acc_next[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      syn_valid <= 1'b0;
      syn_bank  <= '0;
      err_flag  <= 1'b0;
    end else begin
      syn_valid <= accept_eof;
      if (accept_eof) begin
        for (int g = 0; g < N_ROOTS; g++) syn_bank[g*GF_W +: GF_W] <= acc_next[g];
        err_flag <= any_nz;
      end
    end
  end

  assert_done_cause_R3: assert property (@(posedge clk) disable iff (rst)
    syn_valid |-> $past(in_valid && in_eof));

  assert_flag_or_R4: assert property (@(posedge clk) disable iff (rst)
    syn_valid |-> (err_flag == (syn_bank != '0)));

  assert_bank_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid && in_eof)) |-> ($stable(syn_bank) && $stable(err_flag)));

endmodule

// File: tb/rs_syndrome_calc_tb.sv
module rs_syndrome_calc_tb;

  localparam int NS = 204;
  localparam int NR = 16;
  localparam int NK = 188;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_sof = 1'b0;
  logic          in_eof = 1'b0;
  logic [7:0]    in_sym = 8'h00;
  logic          syn_valid;
  logic [NR*8-1:0] syn_bank;
  logic          err_flag;

  int checks = 0;
  int errors = 0;

  int gexp [0:509];
  int glog [0:255];
  int gen  [0:NR];
  logic [7:0] cur  [0:NS-1];
  logic [7:0] nxt  [0:NS-1];
  logic [7:0] expb [1:NR];
  logic [7:0] pend [1:NR];
  bit pend_check = 0;
  int seed = 12345;

  always #5 clk = ~clk;

  rs_syndrome_calc u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_sym(in_sym), .syn_valid(syn_valid), .syn_bank(syn_bank), .err_flag(err_flag)
  );

  function automatic int fmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return gexp[glog[a] + glog[b]];
  endfunction

  function automatic int prng();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return (seed >> 8) & 8'hff;
  endfunction

  task automatic check(string req, logic ok, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Horner model in log domain
  task automatic model_cur();
    for (int j = 1; j <= NR; j++) begin
      int s = 0;
      for (int i = 0; i < NS; i++) s = fmul(s, gexp[j]) ^ cur[i];
      expb[j] = 8'(s);
    end
  endtask

  task automatic encode_cur();
    int par [0:NR-1];
    for (int k = 0; k < NR; k++) par[k] = 0;
    for (int i = 0; i < NK; i++) begin
      int fb;
      cur[i] = 8'(prng());
      fb = cur[i] ^ par[NR-1];
      for (int k = NR-1; k > 0; k--) par[k] = par[k-1] ^ fmul(fb, gen[k]);
      par[0] = fmul(fb, gen[0]);
    end
    for (int k = 0; k < NR; k++) cur[NK + k] = 8'(par[NR-1-k]);
  endtask

  task automatic check_bank(string req, logic [7:0] e [1:NR]);
    bit ok = 1; bit any = 0; int bad = 1;
    for (int j = 1; j <= NR; j++) begin
      if (e[j] != 0) any = 1;
      if (ok && syn_bank[(j-1)*8 +: 8] != e[j]) begin ok = 0; bad = j; end
    end
    check({req, " R2 R10"}, ok, $sformatf("S%0d", bad), syn_bank[(bad-1)*8 +: 8], e[bad]);
    check({req, " R4"}, err_flag == any, "err_flag", err_flag, any);
  endtask

  // Drive cur; gap>0 inserts an idle cycle every gap symbols
  task automatic send_cur(int gap);
    for (int i = 0; i < NS; i++) begin
      if (gap > 0 && i > 0 && (i % gap) == 0) begin
        @(negedge clk);
        in_valid = 0; in_sof = 1; in_eof = 1; in_sym = 8'h5A;
      end
      @(negedge clk);
      if (pend_check) begin
        check("R8", syn_valid == 1'b1, "syn_valid at junction", syn_valid, 1);
        check_bank("R8", pend);
        pend_check = 0;
      end
      in_valid = 1; in_sof = (i == 0); in_eof = (i == NS-1); in_sym = cur[i];
    end
  endtask

  task automatic finish_cw(string req);
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_sym = 8'h00;
    check({req, " R3 R11"}, syn_valid == 1'b1, "syn_valid after eof", syn_valid, 1);
    check_bank(req, expb);
    @(negedge clk);
    check({req, " R3"}, syn_valid == 1'b0, "syn_valid second cycle", syn_valid, 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1", syn_valid == 0 && err_flag == 0 && syn_bank == '0, "reset outputs",
          int'(syn_valid) + int'(err_flag) + int'(syn_bank != '0), 0);
    rst = 0;
    @(negedge clk);
    check("R1", syn_valid == 0 && syn_bank == '0, "after reset", int'(syn_bank != '0), 0);
  endtask

  task automatic test_encoded();
    encode_cur();
    for (int j = 1; j <= NR; j++) expb[j] = 8'h00;
    send_cur(0);
    finish_cw("R5");
  endtask

  task automatic test_single_error(int p, int e);
    encode_cur();
    cur[p] = cur[p] ^ 8'(e);
    for (int j = 1; j <= NR; j++) expb[j] = 8'(gexp[(glog[e] + j * (NS-1-p)) % 255]);
    send_cur(0);
    finish_cw("R2");
  endtask

  task automatic test_gaps();
    for (int i = 0; i < NS; i++) cur[i] = 8'(prng());
    model_cur();
    send_cur(0);
    finish_cw("R2");
    send_cur(7);
    finish_cw("R6");
  endtask

  task automatic test_restart();
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (i == 0); in_eof = 0; in_sym = 8'(prng() | 1);
    end
    encode_cur();
    cur[100] = cur[100] ^ 8'h33;
    model_cur();
    send_cur(0);
    finish_cw("R7");
  endtask

  task automatic test_back_to_back();
    for (int i = 0; i < NS; i++) cur[i] = 8'(prng());
    model_cur();
    send_cur(0);
    for (int j = 1; j <= NR; j++) pend[j] = expb[j];
    pend_check = 1;
    encode_cur();
    cur[NS-1] = cur[NS-1] ^ 8'h01;
    model_cur();
    send_cur(0);
    finish_cw("R8");
  endtask

  task automatic test_hold();
    logic [NR*8-1:0] snap;
    logic snapf;
    snap = syn_bank; snapf = err_flag;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      in_valid = 0; in_sof = k[0]; in_eof = ~k[0]; in_sym = 8'(prng());
    end
    @(negedge clk);
    in_sof = 0; in_eof = 0;
    check("R9", syn_bank == snap && err_flag == snapf, "bank held", int'(syn_bank != snap), 0);
    check("R9 R3", syn_valid == 1'b0, "no pulse while idle", syn_valid, 0);
  endtask

  initial begin
    int x = 1;
    for (int i = 0; i < 255; i++) begin
      gexp[i] = x; gexp[i+255] = x; glog[x] = i;
      x = x << 1;
      if (x & 9'h100) x = x ^ 9'h11D;
    end
    gexp[510 - 1] = gexp[254];
    glog[0] = 0;
    for (int k = 0; k <= NR; k++) gen[k] = 0;
    gen[0] = 1;
    for (int j = 1; j <= NR; j++) begin
      for (int k = j; k > 0; k--) gen[k] = gen[k-1] ^ fmul(gen[k], gexp[j]);
      gen[0] = fmul(gen[0], gexp[j]);
    end

    test_reset();
    test_encoded();
    test_single_error(0, 8'h01);
    test_single_error(NS-1, 8'hC7);
    test_single_error(97, 8'h40);
    test_gaps();
    test_restart();
    test_back_to_back();
    test_hold();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule